// File: doc/BRIEF.md
# 16-bit I/O Expansion Card Bus Interface with One DMA Channel

This block is the card-side front end of a 16-bit I/O peripheral on a PC expansion bus. It watches the slave address lines and, while the address-enable line is low, matches address bits 9 to 4 against a base address set by parameter. Address bits 3 to 1 then pick one of a few word registers. A match is answered at once with the 16-bit-device signal, so the host uses both data byte lanes. Register reads and writes are served from a small register set. Every accepted command is stretched by a fixed number of clock cycles, during which the card pulls the channel-ready line low.

For DMA, words written to the data register queue up in a small buffer. While the buffer holds data and no acknowledge is present, the card raises its DMA request. The DMA controller grants the bus by raising address-enable and pulling the acknowledge low. During the read strobe of that cycle the card drives the oldest buffered word onto the data bus, and it removes the word when the cycle completes. If terminal count is high when a DMA word completes, the card raises its interrupt request. The request stays up until software writes a one to bit 0 of the status register.

Open-drain outputs (the 16-bit-device response and channel-ready) are modelled as active-high "pull low" enables. The tri-state data bus is modelled as a driven word plus an output enable.

Top module: `isa_dma_card`

## Requirements
- R1: `io16Low` is high in exactly those cycles where `addrEnable` is low and `busAddr[9:4]` equals `BASE_ADDR[9:4]`, with no delay.
- R2: While `addrEnable` is high, an address match has no effect: no `io16Low`, no read data, no wait states and no register change.
- R3: During a matched read strobe, `dataOe` is high and `dataOut` returns the register picked by `busAddr[3:1]`: 0 gives the oldest buffered word (0 when empty), 1 gives status, 2 gives scratch, and any other value reads 0. At all other times `dataOe` is low, except as R7 allows.
- R4: A write to scratch (word 2) updates bits 7:0 only when `busAddr[0]` is 0 and bits 15:8 only when `byteHighEnN` is 0.
- R5: Each accepted command pulls `chRdyLow` high for exactly `WAIT_CYCLES` cycles, starting in the first cycle the strobe is seen. The command takes effect at the clock edge that ends the first cycle with `chRdyLow` low and the strobe still active, and it takes effect once only.
- R6: `dmaReq` is high exactly when the buffer holds at least one word and `dmaAckN` is high.
- R7: While both `dmaAckN` and `ioRdN` are low, `dataOe` is high and `dataOut` holds the oldest buffered word. That word is removed when the command takes effect.
- R8: If `termCount` is high when a DMA word takes effect, `irqOut` rises on the next cycle. It stays high until a write to word 1 with `busAddr[0]` = 0 and `dataIn[0]` = 1. Status bit 0 is the interrupt flag, bit 1 is buffer empty, and bit 2 is buffer full.
- R9: A write to word 0 appends `dataIn` to a buffer of `FIFO_DEPTH` words. Writes made while the buffer is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; bus inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 10 | Slave address lines 9:0 |
| addrEnable | input | 1 | High while a DMA controller owns the bus |
| byteHighEnN | input | 1 | Low when the high byte lane takes part |
| ioRdN | input | 1 | I/O read strobe, active low |
| ioWrN | input | 1 | I/O write strobe, active low |
| dataIn | input | 16 | Data bus as seen by the card |
| dataOut | output | 16 | Word the card drives onto the data bus |
| dataOe | output | 1 | Data bus output enable (low means high impedance) |
| io16Low | output | 1 | Pull the 16-bit-device line low |
| chRdyLow | output | 1 | Pull channel-ready low (insert wait states) |
| dmaReq | output | 1 | DMA request |
| dmaAckN | input | 1 | DMA acknowledge, active low |
| termCount | input | 1 | Terminal count from the DMA controller |
| irqOut | output | 1 | Interrupt request |

## Verification
`io16Low`, `dmaReq`, `dataOe` and `dataOut` are combinational answers to the bus inputs, so they are due in the same cycle as the stimulus. `chRdyLow` starts in that cycle too and lasts `WAIT_CYCLES` cycles. Register and buffer changes, and the rise of `irqOut`, become visible one cycle after the edge where the command takes effect. The bench changes inputs just after a rising edge. A behavioural model reads those inputs at the falling edge, compares every output against its own state there, and then advances that state for the edge that follows. Each result is therefore checked in exactly the cycle it is due.

// File: rtl/isa_card_pkg.sv
package isa_card_pkg;

  localparam int SEL_W  = 3;
  localparam int WORD_W = 16;

  localparam logic [SEL_W-1:0] SEL_DATA    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_STATUS  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SCRATCH = 3'd2;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_WAIT = 2'd1,
    CMD_HELD = 2'd2
  } cmdState_t;

  // one-cycle strobes from the controller to the datapath
  typedef struct packed {
    logic pushWord;
    logic popWord;
    logic writeLo;
    logic writeHi;
    logic clearIrq;
    logic setIrq;
  } cardStrobes_t;

endpackage

// File: rtl/isa_card_ctrl.sv
module isa_card_ctrl
  import isa_card_pkg::*;
#(
  parameter int          ADDR_W      = 10,
  parameter logic [9:0]  BASE_ADDR   = 10'h300,
  parameter int          WAIT_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               addrEnable,
  input  logic               byteHighEnN,
  input  logic               ioRdN,
  input  logic               ioWrN,
  input  logic               dmaAckN,
  input  logic               termCount,
  input  logic               fifoNotEmpty,
  output cardStrobes_t       strobes,
  output logic [SEL_W-1:0]   regSel,
  output logic               dmaSel,
  output logic               dataOe,
  output logic               io16Low,
  output logic               chRdyLow,
  output logic               dmaReq
);

  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((WAIT_CYCLES > 0) ? WAIT_CYCLES - 1 : 0);
  localparam bit HAS_WAIT = (WAIT_CYCLES != 0);

  cmdState_t        state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             hit, regRd, regWr, dmaRd, cmdLow, commit;

  // address decode, suppressed while a DMA controller owns the bus
  assign hit    = !addrEnable && (busAddr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign regRd  = hit && !ioRdN;
  assign regWr  = hit && !ioWrN;
  assign dmaRd  = !dmaAckN && !ioRdN;
  assign cmdLow = regRd || regWr || dmaRd;

  assign regSel  = busAddr[SEL_W:1];
  assign dmaSel  = dmaRd;
  assign dataOe  = regRd || dmaRd;
  assign io16Low = hit;
  assign dmaReq  = fifoNotEmpty && dmaAckN;

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    commit      = 1'b0;
    chRdyLow    = 1'b0;
    unique case (state)
      CMD_IDLE: begin
        if (cmdLow) begin
          if (HAS_WAIT) begin
            chRdyLow    = 1'b1;
            waitCntNext = CNT_LOAD;
            stateNext   = CMD_WAIT;
          end else begin
            commit    = 1'b1;
            stateNext = CMD_HELD;
          end
        end
      end
      CMD_WAIT: begin
        if (!cmdLow) begin
          stateNext = CMD_IDLE;
        end else if (waitCnt == '0) begin
          commit    = 1'b1;
          stateNext = CMD_HELD;
        end else begin
          chRdyLow    = 1'b1;
          waitCntNext = waitCnt - 1'b1;
        end
      end
      default: begin
        if (!cmdLow) stateNext = CMD_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CMD_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.popWord  = commit && dmaRd;
    strobes.setIrq   = commit && dmaRd && termCount;
    strobes.pushWord = commit && regWr && (regSel == SEL_DATA);
    strobes.clearIrq = commit && regWr && (regSel == SEL_STATUS) && !busAddr[0];
    strobes.writeLo  = commit && regWr && (regSel == SEL_SCRATCH) && !busAddr[0];
    strobes.writeHi  = commit && regWr && (regSel == SEL_SCRATCH) && !byteHighEnN;
  end

endmodule

// File: rtl/isa_card_dpath.sv
module isa_card_dpath
  import isa_card_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cardStrobes_t       strobes,
  input  logic [SEL_W-1:0]   regSel,
  input  logic               dmaSel,
  input  logic [WORD_W-1:0]  dataIn,
  output logic [WORD_W-1:0]  dataOut,
  output logic               fifoNotEmpty,
  output logic               irqFlag
);

  localparam int PTR_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int COUNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0]   PTR_LAST  = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [COUNT_W-1:0] COUNT_MAX = COUNT_W'(FIFO_DEPTH);

  logic [WORD_W-1:0]  fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [COUNT_W-1:0] fillCount;
  logic [WORD_W-1:0]  scratchReg, headWord, statusWord, regWord;
  logic               fifoFull, fifoEmpty, doPush, doPop;

  assign fifoEmpty    = (fillCount == '0);
  assign fifoFull     = (fillCount == COUNT_MAX);
  assign fifoNotEmpty = !fifoEmpty;
  assign doPush       = strobes.pushWord && !fifoFull;
  assign doPop        = strobes.popWord && !fifoEmpty;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (doPush) wrPtr <= bumpPtr(wrPtr);
      if (doPop)  rdPtr <= bumpPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratchReg <= '0;
      irqFlag    <= 1'b0;
    end else begin
      if (strobes.writeLo) scratchReg[7:0]  <= dataIn[7:0];
      if (strobes.writeHi) scratchReg[15:8] <= dataIn[15:8];
      if (strobes.setIrq)
        irqFlag <= 1'b1;
      else if (strobes.clearIrq && dataIn[0])
        irqFlag <= 1'b0;
    end
  end

  assign headWord   = fifoEmpty ? '0 : fifoMem[rdPtr];
  assign statusWord = {{(WORD_W-3){1'b0}}, fifoFull, fifoEmpty, irqFlag};

  always_comb begin
    case (regSel)
      SEL_DATA:    regWord = headWord;
      SEL_STATUS:  regWord = statusWord;
      SEL_SCRATCH: regWord = scratchReg;
      default:     regWord = '0;
    endcase
  end

  assign dataOut = dmaSel ? headWord : regWord;

endmodule

// File: rtl/isa_dma_card.sv
module isa_dma_card
  import isa_card_pkg::*;
#(
  parameter logic [9:0] BASE_ADDR   = 10'h300,
  parameter int         WAIT_CYCLES = 2,
  parameter int         FIFO_DEPTH  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [9:0]  busAddr,
  input  logic        addrEnable,
  input  logic        byteHighEnN,
  input  logic        ioRdN,
  input  logic        ioWrN,
  input  logic [15:0] dataIn,
  output logic [15:0] dataOut,
  output logic        dataOe,
  output logic        io16Low,
  output logic        chRdyLow,
  output logic        dmaReq,
  input  logic        dmaAckN,
  input  logic        termCount,
  output logic        irqOut
);

  cardStrobes_t     strobes;
  logic [SEL_W-1:0] regSel;
  logic             dmaSel, fifoNotEmpty;

  isa_card_ctrl #(
    .ADDR_W      (10),
    .BASE_ADDR   (BASE_ADDR),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busAddr      (busAddr),
    .addrEnable   (addrEnable),
    .byteHighEnN  (byteHighEnN),
    .ioRdN        (ioRdN),
    .ioWrN        (ioWrN),
    .dmaAckN      (dmaAckN),
    .termCount    (termCount),
    .fifoNotEmpty (fifoNotEmpty),
    .strobes      (strobes),
    .regSel       (regSel),
    .dmaSel       (dmaSel),
    .dataOe       (dataOe),
    .io16Low      (io16Low),
    .chRdyLow     (chRdyLow),
    .dmaReq       (dmaReq)
  );

  isa_card_dpath #(
    .FIFO_DEPTH (FIFO_DEPTH)
  ) i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .regSel       (regSel),
    .dmaSel       (dmaSel),
    .dataIn       (dataIn),
    .dataOut      (dataOut),
    .fifoNotEmpty (fifoNotEmpty),
    .irqFlag      (irqOut)
  );

endmodule

// File: rtl/isa_dma_card_checker.sv
module isa_dma_card_checker (
  input logic        clk,
  input logic        rstN,
  input logic        addrEnable,
  input logic        ioRdN,
  input logic        ioWrN,
  input logic        dataOe,
  input logic        io16Low,
  input logic        chRdyLow,
  input logic        dmaReq,
  input logic        dmaAckN,
  input logic        termCount,
  input logic        irqOut
);

  p_no_io16_when_dma_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrEnable |-> !io16Low);

  p_drive_needs_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !ioRdN);

  p_wait_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    chRdyLow |-> (!ioRdN || !ioWrN));

  p_req_drops_on_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dmaAckN |-> !dmaReq);

  p_irq_needs_tc_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(termCount));

  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && ioWrN) |=> irqOut);

endmodule

bind isa_dma_card isa_dma_card_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .addrEnable (addrEnable),
  .ioRdN      (ioRdN),
  .ioWrN      (ioWrN),
  .dataOe     (dataOe),
  .io16Low    (io16Low),
  .chRdyLow   (chRdyLow),
  .dmaReq     (dmaReq),
  .dmaAckN    (dmaAckN),
  .termCount  (termCount),
  .irqOut     (irqOut)
);

// File: tb/test_isa_dma_card.sv
module test_isa_dma_card;

  localparam logic [9:0] BASE  = 10'h300;
  localparam int         W     = 2;
  localparam int         DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [9:0]  busAddr;
  logic        addrEnable, byteHighEnN, ioRdN, ioWrN, dmaAckN, termCount;
  logic [15:0] dataIn, dataOut;
  logic        dataOe, io16Low, chRdyLow, dmaReq, irqOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;

  isa_dma_card #(.BASE_ADDR(BASE), .WAIT_CYCLES(W), .FIFO_DEPTH(DEPTH)) i_isa_dma_card (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .addrEnable(addrEnable),
    .byteHighEnN(byteHighEnN), .ioRdN(ioRdN), .ioWrN(ioWrN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .io16Low(io16Low), .chRdyLow(chRdyLow),
    .dmaReq(dmaReq), .dmaAckN(dmaAckN), .termCount(termCount), .irqOut(irqOut)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          q[$];
  logic [15:0] mScr;
  bit          mIrq;
  int          mState, mCnt;

  always @(negedge clk) begin : refModel
    bit          hit, dmaRd, regRd, regWr, cmdLow, commit, expChr, expOe;
    logic [15:0] expData, status;
    int          sel;
    string       dtag;
    if (!rstN) begin
      q.delete(); mScr = '0; mIrq = 0; mState = 0; mCnt = 0;
    end
    hit    = !addrEnable && (busAddr[9:4] == BASE[9:4]);
    dmaRd  = !dmaAckN && !ioRdN;
    regRd  = hit && !ioRdN;
    regWr  = hit && !ioWrN;
    cmdLow = regRd || regWr || dmaRd;
    sel    = int'(busAddr[3:1]);
    status = {13'd0, q.size() == DEPTH, q.size() == 0, mIrq};
    expOe  = regRd || dmaRd;
    expData = 16'h0;
    dtag    = "R3";
    if (dmaRd) begin
      expData = (q.size() != 0) ? 16'(q[0]) : 16'h0; dtag = "R7";
    end else if (sel == 0) begin
      expData = (q.size() != 0) ? 16'(q[0]) : 16'h0; dtag = "R9";
    end else if (sel == 1) begin
      expData = status; dtag = "R8";
    end else if (sel == 2) begin
      expData = mScr; dtag = "R4";
    end
    expChr = (mState == 0 && cmdLow && W > 0) || (mState == 1 && mCnt != 0);

    check(addrEnable ? "R2" : "R1", "io16Low", 16'(io16Low), 16'(hit));
    check(addrEnable ? "R2" : "R5", "chRdyLow", 16'(chRdyLow), 16'(expChr));
    check("R6", "dmaReq", 16'(dmaReq), 16'(q.size() != 0 && dmaAckN));
    check("R8", "irqOut", 16'(irqOut), 16'(mIrq));
    check(dmaRd ? "R7" : "R3", "dataOe", 16'(dataOe), 16'(expOe));
    if (expOe) check(dtag, "dataOut", dataOut, expData);

    if (rstN) begin
      commit = 0;
      if (mState == 0) begin
        if (cmdLow) begin
          if (W == 0) begin commit = 1; mState = 2; end
          else begin mCnt = W - 1; mState = 1; end
        end
      end else if (mState == 1) begin
        if (!cmdLow) mState = 0;
        else if (mCnt == 0) begin commit = 1; mState = 2; end
        else mCnt--;
      end else if (!cmdLow) mState = 0;

      if (commit) begin
        if (dmaRd) begin
          if (q.size() != 0) void'(q.pop_front());
          if (termCount) mIrq = 1;
        end else if (regWr) begin
          if (sel == 0 && q.size() < DEPTH) q.push_back(int'(dataIn));
          if (sel == 1 && !busAddr[0] && dataIn[0]) mIrq = 0;
          if (sel == 2) begin
            if (!busAddr[0])  mScr[7:0]  = dataIn[7:0];
            if (!byteHighEnN) mScr[15:8] = dataIn[15:8];
          end
        end
      end
    end
  end

  task automatic busCycle(input logic [9:0] a, input bit wr, input logic [15:0] d,
                          input bit hiN, input bit aen);
    @(posedge clk); #2;
    busAddr = a; addrEnable = aen; byteHighEnN = hiN; dataIn = d;
    @(posedge clk); #2;
    if (wr) ioWrN = 1'b0; else ioRdN = 1'b0;
    repeat (W + 3) @(posedge clk);
    #2; ioWrN = 1'b1; ioRdN = 1'b1;
    @(posedge clk); #2;
    busAddr = '0; addrEnable = 1'b0; byteHighEnN = 1'b1; dataIn = '0;
  endtask

  task automatic dmaCycle(input bit tc);
    @(posedge clk); #2;
    addrEnable = 1'b1; dmaAckN = 1'b0;
    @(posedge clk); #2;
    ioRdN = 1'b0; termCount = tc;
    repeat (W + 3) @(posedge clk);
    #2; ioRdN = 1'b1; termCount = 1'b0;
    @(posedge clk); #2;
    dmaAckN = 1'b1; addrEnable = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finishRun();
  end

  initial begin : stimulus
    rstN = 1'b0; busAddr = '0; addrEnable = 1'b0; byteHighEnN = 1'b1;
    ioRdN = 1'b1; ioWrN = 1'b1; dmaAckN = 1'b1; termCount = 1'b0; dataIn = '0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R3: status after reset reads empty
    busCycle(10'h302, 0, 16'h0, 1, 0);
    // R4: full word, then low byte only, then high byte only
    busCycle(10'h304, 1, 16'hA55A, 0, 0);
    busCycle(10'h304, 0, 16'h0, 0, 0);
    busCycle(10'h304, 1, 16'h1234, 1, 0);
    busCycle(10'h304, 0, 16'h0, 0, 0);
    busCycle(10'h305, 1, 16'h7700, 0, 0);
    busCycle(10'h304, 0, 16'h0, 0, 0);
    // R2: matching write while address-enable is high is ignored
    busCycle(10'h304, 1, 16'hFFFF, 0, 1);
    busCycle(10'h304, 0, 16'h0, 0, 0);
    // R1: other base gives no response; R3: unused word reads 0
    busCycle(10'h310, 0, 16'h0, 0, 0);
    busCycle(10'h306, 0, 16'h0, 0, 0);
    // R9 / R6: queue three words
    busCycle(10'h300, 1, 16'h1111, 0, 0);
    busCycle(10'h300, 1, 16'h2222, 0, 0);
    busCycle(10'h300, 1, 16'h3333, 0, 0);
    busCycle(10'h300, 0, 16'h0, 0, 0);
    // R7 / R8: DMA drain with terminal count on the last word
    dmaCycle(0);
    dmaCycle(0);
    dmaCycle(1);
    busCycle(10'h302, 0, 16'h0, 0, 0);
    repeat (4) @(posedge clk);
    // R8: write of 0 keeps the flag, write of 1 clears it
    busCycle(10'h302, 1, 16'h0000, 0, 0);
    busCycle(10'h302, 1, 16'h0001, 0, 0);
    busCycle(10'h302, 0, 16'h0, 0, 0);
    // R9: overfill, check full status, drain
    for (int i = 0; i < DEPTH + 1; i++) busCycle(10'h300, 1, 16'(16'h4000 + i), 0, 0);
    busCycle(10'h302, 0, 16'h0, 0, 0);
    for (int i = 0; i < DEPTH; i++) dmaCycle(0);
    busCycle(10'h300, 0, 16'h0, 0, 0);
    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule